// File: doc/BRIEF.md
# Fused 3x3 Convolution Tile Engine

This block holds one square tile of signed 9-bit image pixels together with a 3x3 set of signed 15-bit filter weights and one bias word. On a start pulse it forms the 3x3 weighted sum at every pixel position of the tile in a single clock. Neighbours outside the tile count as zero, so the result keeps the tile's size. The per-position sums go into a bank of wide accumulators. A pass marked as the first input channel overwrites that bank. Any later pass adds to it, so several input channels can be summed for one output channel.

When a pass is marked as the last channel, the engine turns the accumulated sums into output values. It optionally adds the bias, applies an arithmetic right shift, clamps negative values to zero and caps the result at the largest signed 9-bit value. It then takes the maximum of each non-overlapping 2x2 group. For the default 14x14 tile, the resulting 7x7 grid leaves on a valid/ready stream. Weights and pixels are written first through simple write ports. Then one start pulse is issued per input channel.

Top module: `conv_tile_engine`

## Requirements
- R1: After reset, `busy`, `out_valid` and `done` are 0.
- R2: Each position (r,c) of the tile computes the sum over dr,dc in {-1,0,1} of pixel(r+dr,c+dc) times weight slot (dr+1)*3+(dc+1). Pixel (r,c) is written at pixel address r*TILE+c. Positions outside the tile contribute zero. Pixels and weights are signed two's complement.
- R3: A start with `first_ch`=1 loads the accumulators with the new sums. A start with `first_ch`=0 adds the new sums to them.
- R4: The bias is the signed word written at weight slot 9. It is added to every accumulated sum only when `bias_en` was 1 at the last-channel start.
- R5: After the bias stage, each value is arithmetically shifted right by `shift`. Negative results become 0, and results above 255 become 255.
- R6: The output value for pooled cell (i,j) is the maximum of the four activated values at rows 2i..2i+1 and columns 2j..2j+1. The 49 cells leave in raster order, with index i*7+j.
- R7: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_data` holds its value.
- R8: `done` is high for one cycle. It rises in the cycle after the 49th output is accepted. For a start that is not the last channel, it rises in the cycle after that start.
- R9: While `busy`=1, pixel writes, weight writes and start pulses have no effect.
- R10: A start with `last_ch`=0 produces no output beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_we | input | 1 | Pixel write strobe |
| pix_addr | input | 8 | Pixel address, row*TILE+col |
| pix_data | input | 9 | Signed pixel value |
| coef_we | input | 1 | Weight write strobe |
| coef_addr | input | 4 | Weight slot 0..8, bias at slot 9 |
| coef_data | input | 15 | Signed weight or bias |
| start | input | 1 | Begin one channel pass |
| first_ch | input | 1 | Pass overwrites the accumulators |
| last_ch | input | 1 | Pass is followed by activation, pooling and output |
| bias_en | input | 1 | Add bias in the output stage |
| shift | input | 5 | Right shift applied before the clamp |
| busy | output | 1 | Output stream in progress |
| out_valid | output | 1 | Pooled result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 9 | Pooled result, 0..255 |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
The bench builds the engine with its default parameters: a 14x14 tile, 9-bit pixels, 15-bit weights and 32-bit accumulators. All 196 window positions are therefore present, including every corner and edge case of the zero border, and all 49 pooled cells go through the stream. With full-range random data and a 5-bit shift, both clamp limits are reached. A two-channel sequence shows accumulation across passes. Random backpressure exercises the stall behaviour, and writes injected mid-stream show that the stored data stays unchanged.

// File: rtl/conv_tile_pkg.sv
// Shared constants and types for the convolution tile engine.
// Assumes a fixed 3x3 kernel whose bias occupies the slot after the taps.
package conv_tile_pkg;
    localparam int KTAPS   = 9;          // 3x3 kernel taps
    localparam int BIAS_SLOT = KTAPS;    // bias stored right after the taps
    localparam int NSLOT   = KTAPS + 1;
    localparam int CADR_W  = 4;

    typedef enum logic {ST_IDLE, ST_STREAM} eng_state_t;
endpackage

// File: rtl/conv_tile_store.sv
// Register storage for one pixel tile and the weight/bias slots.
// Writes land only while the engine is idle; out-of-range addresses are dropped.
module conv_tile_store
    import conv_tile_pkg::*;
#(
    parameter int TILE   = 14,
    parameter int PIX_W  = 9,
    parameter int COEF_W = 15,
    localparam int NPIX  = TILE * TILE,
    localparam int PADR_W = $clog2(NPIX)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      busy,
    input  logic                      pix_we,
    input  logic [PADR_W-1:0]         pix_addr,
    input  logic [PIX_W-1:0]          pix_data,
    input  logic                      coef_we,
    input  logic [CADR_W-1:0]         coef_addr,
    input  logic [COEF_W-1:0]         coef_data,
    output logic [NPIX*PIX_W-1:0]     pix_flat,
    output logic [NSLOT*COEF_W-1:0]   coef_flat
);
    logic [NPIX*PIX_W-1:0]   pix_mem;
    logic [NSLOT*COEF_W-1:0] coef_mem;

    // Capture host writes when the engine is not streaming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_mem  <= '0;
            coef_mem <= '0;
        end else if (!busy) begin
            if (pix_we && (int'(pix_addr) < NPIX))
                pix_mem[int'(pix_addr)*PIX_W +: PIX_W] <= pix_data;
            if (coef_we && (int'(coef_addr) < NSLOT))
                coef_mem[int'(coef_addr)*COEF_W +: COEF_W] <= coef_data;
        end
    end

    assign pix_flat  = pix_mem;
    assign coef_flat = coef_mem;

    // Stored data must not move while the stream is running.
    assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(pix_mem) && $stable(coef_mem)));
endmodule

// File: rtl/conv_tile_accum.sv
// Parallel 3x3 window sums over the whole tile plus per-position accumulators.
// Assumes signed operands; positions beyond the tile border read as zero.
module conv_tile_accum
    import conv_tile_pkg::*;
#(
    parameter int TILE   = 14,
    parameter int PIX_W  = 9,
    parameter int COEF_W = 15,
    parameter int ACC_W  = 32,
    localparam int NPIX  = TILE * TILE
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      go,
    input  logic                      first,
    input  logic [NPIX*PIX_W-1:0]     pix_flat,
    input  logic [NSLOT*COEF_W-1:0]   coef_flat,
    output logic [NPIX*ACC_W-1:0]     acc_flat
);
    for (genvar r = 0; r < TILE; r++) begin : g_row
        for (genvar c = 0; c < TILE; c++) begin : g_col
            logic signed [ACC_W-1:0] wsum;
            logic signed [ACC_W-1:0] acc_q;

            // Combinational 3x3 weighted sum with zero padding.
            always_comb begin
                logic signed [PIX_W-1:0]        p;
                logic signed [COEF_W-1:0]       w;
                logic signed [PIX_W+COEF_W-1:0] prod;
                int rr;
                int cc;
                wsum = '0;
                for (int k = 0; k < KTAPS; k++) begin
                    rr = r + k / 3 - 1;
                    cc = c + k % 3 - 1;
                    if (rr >= 0 && rr < TILE && cc >= 0 && cc < TILE) begin
                        p    = pix_flat[(rr*TILE+cc)*PIX_W +: PIX_W];
                        w    = coef_flat[k*COEF_W +: COEF_W];
                        prod = p * w;
                        wsum = wsum + ACC_W'(prod);
                    end
                end
            end

            // Load or add the window sum on an accepted pass.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    acc_q <= '0;
                else if (go)
                    acc_q <= first ? wsum : acc_q + wsum;
            end

            assign acc_flat[(r*TILE+c)*ACC_W +: ACC_W] = acc_q;
        end
    end
endmodule

// File: rtl/conv_tile_post.sv
// Output stage: optional bias, arithmetic shift, clamp to 0..max, 2x2 max pool.
// Assumes an even tile size; all cells are evaluated combinationally.
module conv_tile_post #(
    parameter int TILE    = 14,
    parameter int PIX_W   = 9,
    parameter int COEF_W  = 15,
    parameter int ACC_W   = 32,
    parameter int SHIFT_W = 5,
    localparam int NPIX   = TILE * TILE,
    localparam int POOL   = TILE / 2,
    localparam int NOUT   = POOL * POOL
) (
    input  logic [NPIX*ACC_W-1:0]  acc_flat,
    input  logic [COEF_W-1:0]      bias,
    input  logic                   bias_en,
    input  logic [SHIFT_W-1:0]     shift,
    output logic [NOUT*PIX_W-1:0]  pool_flat
);
    localparam int TOP_VAL = (1 << (PIX_W - 1)) - 1;

    logic [PIX_W-1:0] act [NPIX];

    for (genvar i = 0; i < NPIX; i++) begin : g_act
        logic signed [ACC_W:0] biased;
        logic signed [ACC_W:0] shifted;
        // Bias, shift and clamp one accumulated sum.
        always_comb begin
            biased = (ACC_W+1)'($signed(acc_flat[i*ACC_W +: ACC_W]));
            if (bias_en)
                biased = biased + (ACC_W+1)'($signed(bias));
            shifted = biased >>> shift;
            if (shifted < 0)
                act[i] = '0;
            else if (shifted > TOP_VAL)
                act[i] = PIX_W'(TOP_VAL);
            else
                act[i] = shifted[PIX_W-1:0];
        end
    end

    for (genvar pr = 0; pr < POOL; pr++) begin : g_prow
        for (genvar pc = 0; pc < POOL; pc++) begin : g_pcol
            localparam int BASE = (2*pr)*TILE + 2*pc;
            logic [PIX_W-1:0] m;
            // Maximum over the 2x2 group.
            always_comb begin
                m = act[BASE];
                if (act[BASE+1]      > m) m = act[BASE+1];
                if (act[BASE+TILE]   > m) m = act[BASE+TILE];
                if (act[BASE+TILE+1] > m) m = act[BASE+TILE+1];
            end
            assign pool_flat[(pr*POOL+pc)*PIX_W +: PIX_W] = m;
        end
    end
endmodule

// File: rtl/conv_tile_engine.sv
// Top of the fused convolution tile engine: storage, parallel accumulate,
// output stage and a raster-order valid/ready stream of pooled results.
// Assumes the host loads weights and pixels before pulsing start.
module conv_tile_engine
    import conv_tile_pkg::*;
#(
    parameter int TILE    = 14,
    parameter int PIX_W   = 9,
    parameter int COEF_W  = 15,
    parameter int ACC_W   = 32,
    parameter int SHIFT_W = 5,
    localparam int NPIX   = TILE * TILE,
    localparam int PADR_W = $clog2(NPIX),
    localparam int POOL   = TILE / 2,
    localparam int NOUT   = POOL * POOL,
    localparam int OIDX_W = $clog2(NOUT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pix_we,
    input  logic [PADR_W-1:0]   pix_addr,
    input  logic [PIX_W-1:0]    pix_data,
    input  logic                coef_we,
    input  logic [CADR_W-1:0]   coef_addr,
    input  logic [COEF_W-1:0]   coef_data,
    input  logic                start,
    input  logic                first_ch,
    input  logic                last_ch,
    input  logic                bias_en,
    input  logic [SHIFT_W-1:0]  shift,
    output logic                busy,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [PIX_W-1:0]    out_data,
    output logic                done
);
    eng_state_t               state;
    logic [OIDX_W-1:0]        out_idx;
    logic                     bias_en_q;
    logic [SHIFT_W-1:0]       shift_q;
    logic                     go;
    logic [NPIX*PIX_W-1:0]    pix_flat;
    logic [NSLOT*COEF_W-1:0]  coef_flat;
    logic [NPIX*ACC_W-1:0]    acc_flat;
    logic [NOUT*PIX_W-1:0]    pool_flat;

    assign busy      = (state == ST_STREAM);
    assign go        = start && !busy;
    assign out_valid = busy;
    assign out_data  = pool_flat[int'(out_idx)*PIX_W +: PIX_W];

    conv_tile_store #(.TILE(TILE), .PIX_W(PIX_W), .COEF_W(COEF_W)) u_store (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .pix_we(pix_we), .pix_addr(pix_addr), .pix_data(pix_data),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
        .pix_flat(pix_flat), .coef_flat(coef_flat)
    );

    conv_tile_accum #(.TILE(TILE), .PIX_W(PIX_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .go(go), .first(first_ch),
        .pix_flat(pix_flat), .coef_flat(coef_flat), .acc_flat(acc_flat)
    );

    conv_tile_post #(.TILE(TILE), .PIX_W(PIX_W), .COEF_W(COEF_W),
                     .ACC_W(ACC_W), .SHIFT_W(SHIFT_W)) u_post (
        .acc_flat(acc_flat),
        .bias(coef_flat[BIAS_SLOT*COEF_W +: COEF_W]),
        .bias_en(bias_en_q), .shift(shift_q), .pool_flat(pool_flat)
    );

    // Pass sequencing, output index and end-of-pass pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            out_idx   <= '0;
            bias_en_q <= 1'b0;
            shift_q   <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == ST_IDLE) begin
                if (go) begin
                    bias_en_q <= bias_en;
                    shift_q   <= shift;
                    out_idx   <= '0;
                    if (last_ch) state <= ST_STREAM;
                    else         done  <= 1'b1;
                end
            end else if (out_ready) begin
                if (int'(out_idx) == NOUT - 1) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end else begin
                    out_idx <= out_idx + 1'b1;
                end
            end
        end
    end

    // A stalled beat keeps its value.
    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // The end pulse never overlaps a live beat.
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

    // Every stream begins at raster cell zero.
    assert_stream_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_idx == '0));

    // A pass that is not the last must not open the stream.
    assert_no_stream_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !last_ch) |=> !out_valid);
endmodule

// File: tb/conv_tile_engine_bench.sv
// Self-checking bench with a behavioural model of the tile pass.
module conv_tile_engine_bench;
    localparam int TILE = 14;
    localparam int NPIX = TILE * TILE;
    localparam int POOL = TILE / 2;
    localparam int NOUT = POOL * POOL;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_we = 0, coef_we = 0, start = 0, first_ch = 0, last_ch = 0, bias_en = 0;
    logic [7:0] pix_addr = 0;
    logic [8:0] pix_data = 0;
    logic [3:0] coef_addr = 0;
    logic [14:0] coef_data = 0;
    logic [4:0] shift = 0;
    logic       out_ready = 0;
    logic       busy, out_valid, done;
    logic [8:0] out_data;

    int n_checks = 0;
    int n_errs   = 0;
    int pm [NPIX];
    int cm [10];
    longint am [NPIX];
    int ex [NOUT];

    always #2 clk = ~clk;

    conv_tile_engine u_conv_tile_engine (
        .clk(clk), .rst_n(rst_n), .pix_we(pix_we), .pix_addr(pix_addr), .pix_data(pix_data),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
        .start(start), .first_ch(first_ch), .last_ch(last_ch), .bias_en(bias_en),
        .shift(shift), .busy(busy), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .done(done)
    );

    task automatic chk(string req, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put_pixels(int lo, int hi);
        for (int i = 0; i < NPIX; i++) begin
            pm[i] = lo + int'($urandom_range(hi - lo));
            @(negedge clk);
            pix_we = 1; pix_addr = 8'(i); pix_data = 9'(pm[i]);
        end
        @(negedge clk); pix_we = 0;
    endtask

    task automatic put_coefs(int lo, int hi);
        for (int k = 0; k < 10; k++) begin
            cm[k] = lo + int'($urandom_range(hi - lo));
            @(negedge clk);
            coef_we = 1; coef_addr = 4'(k); coef_data = 15'(cm[k]);
        end
        @(negedge clk); coef_we = 0;
    endtask

    // Reference: zero-padded 3x3 sum per position, load or accumulate.
    task automatic model_pass(bit first);
        for (int r = 0; r < TILE; r++)
            for (int c = 0; c < TILE; c++) begin
                longint s = 0;
                for (int dr = -1; dr <= 1; dr++)
                    for (int dc = -1; dc <= 1; dc++)
                        if (r+dr >= 0 && r+dr < TILE && c+dc >= 0 && c+dc < TILE)
                            s += longint'(pm[(r+dr)*TILE + c+dc]) * cm[(dr+1)*3 + dc+1];
                am[r*TILE+c] = first ? s : am[r*TILE+c] + s;
            end
    endtask

    function automatic int act_of(longint v, bit ben, int sh);
        longint t = v + (ben ? longint'(cm[9]) : 0);
        t = t >>> sh;
        if (t < 0) return 0;
        if (t > 255) return 255;
        return int'(t);
    endfunction

    task automatic model_out(bit ben, int sh);
        for (int i = 0; i < POOL; i++)
            for (int j = 0; j < POOL; j++) begin
                int m = 0;
                for (int a = 0; a < 2; a++)
                    for (int b = 0; b < 2; b++) begin
                        int v = act_of(am[(2*i+a)*TILE + 2*j+b], ben, sh);
                        if (v > m) m = v;
                    end
                ex[i*POOL+j] = m;
            end
    endtask

    task automatic pulse_start(bit f, bit l, bit ben, int sh);
        @(negedge clk);
        start = 1; first_ch = f; last_ch = l; bias_en = ben; shift = 5'(sh);
        @(negedge clk);
        start = 0;
    endtask

    // Per-cycle comparison of the stream against the model, random backpressure.
    task automatic drain(string tag, bit inject);
        int k = 0;
        int cyc = 0;
        while (k < NOUT) begin
            chk({tag, " R6 valid"}, out_valid, 1);
            chk({tag, " R6 data"}, out_data, ex[k]);
            chk({tag, " R8 early done"}, done, 0);
            chk({tag, " R9 busy"}, busy, 1);
            out_ready = ($urandom_range(2) != 0);
            if (inject && cyc == 5) begin
                pix_we = 1; pix_addr = 8'd0; pix_data = 9'h0AA;
                coef_we = 1; coef_addr = 4'd4; coef_data = 15'h1234;
                start = 1; first_ch = 1; last_ch = 1;
            end else begin
                pix_we = 0; coef_we = 0; start = 0;
            end
            @(posedge clk);
            if (out_ready) k++;
            cyc++;
            @(negedge clk);
            out_ready = 0; pix_we = 0; coef_we = 0; start = 0;
        end
        chk({tag, " R8 done"}, done, 1);
        chk({tag, " R7 valid off"}, out_valid, 0);
        @(negedge clk);
        chk({tag, " R8 done width"}, done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  Result: errors=%0d of %0d checks", n_errs, n_checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 done", done, 0);
        rst_n = 1;

        // R2 R5 R6: single channel, small values, no bias.
        put_coefs(-8, 8);
        put_pixels(-20, 30);
        model_pass(1); model_out(0, 3);
        pulse_start(1, 1, 0, 3);
        drain("T2 R2", 0);

        // R4: bias applied.
        model_out(1, 2);
        pulse_start(1, 1, 1, 2);
        drain("T3 R4", 0);

        // R3 R10 R8: two-channel accumulation.
        put_pixels(-40, 40);
        model_pass(1);
        pulse_start(1, 0, 0, 0);
        chk("T4 R8 done after partial", done, 1);
        chk("T4 R10 no output", out_valid, 0);
        @(negedge clk);
        chk("T4 R10 still no output", out_valid, 0);
        chk("T4 R8 done single", done, 0);
        put_pixels(-40, 40);
        model_pass(0); model_out(1, 4);
        pulse_start(0, 1, 1, 4);
        drain("T4 R3", 0);

        // R5: full-range data reaches both clamp limits; inject writes mid-stream (R9).
        put_coefs(-16384, 16383);
        put_pixels(-256, 255);
        model_pass(1); model_out(0, 16);
        pulse_start(1, 1, 0, 16);
        drain("T5 R5", 1);

        // R9: the stored tile and weights are unchanged after the injection.
        model_pass(1); model_out(0, 16);
        pulse_start(1, 1, 0, 16);
        drain("T6 R9", 0);

        $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule